// File: doc/BRIEF.md
# Column Command Decoder with Posted-Write Buffer

This block sits behind the command slot of a DRAM device model. Each slot carries a column word and a companion word. The column word has a select flag, a device field, a four-bit column opcode, a bank and a column address. The companion word has a mask flag, a device field, a five-bit extended opcode, a bank and two byte masks. Both device fields are compared against a programmable device ID. The block turns one accepted slot into a short, fixed-order train of one-cycle strobes. These cover write-buffer retire, buffer load, column read, bank precharge, calibrate (optionally with sample) and standby entry.

Writes are posted. The column address, bank, data and byte masks of a write go into a single-entry buffer. That entry is retired toward the sense amplifiers only when a later write, or a precharge on this device, needs it out of the way. The opcode bits are orthogonal, so one code can carry, for example, a write together with a standby request. A power-state flag tracks whether the device is attentive, and therefore able to take column commands, or in standby. A wake input brings it back from standby.

Top module: `col_cmd_top`

## Requirements
- R1: After reset, `busy` is 0, `attn` is 1, no strobe is active and the write buffer is empty, so the first write produces no retire strobe.
- R2: A column word acts only if `cw_sel` is 1 and `cw_dev` equals `dev_id`. An extended word acts only if `xw_mask` is 0 and `xw_dev` equals `dev_id`. Otherwise the word produces no strobe.
- R3: While `attn` is 0, slots are ignored and `busy` stays 0. A `wake` pulse while in standby sets `attn` to 1 on the next clock edge.
- R4: The low three bits of `cw_op` decode as follows: 000 none, 001 write, 011 read, 100 precharge, 101 write then precharge, 111 read then precharge. Codes 010 and 110 do nothing. A read strobe shows the word's bank and column on `rd_bank`/`rd_col`.
- R5: A write retires the current buffer entry first, if one is valid, and then loads the new bank, column, data and mask. The retire strobe shows the previous entry.
- R6: A plain precharge (100) retires the buffer if it is valid, then precharges `cw_bank`.
- R7: Write-then-precharge (101) issues retire of the old entry (if valid), then load, then retire of the new entry, then precharge.
- R8: Read-then-precharge (111) issues read, then precharge. If the buffer is valid, a retire precedes the read.
- R9: `cw_op[3]` = 1 or `xw_op[1]` = 1 adds a standby strobe as the last step. After that strobe, `attn` is 0.
- R10: When `xw_mask` is 1, `ret_mask` of the entry written by the same slot is {`xw_mask_b`, `xw_mask_a`} (bits 15:8 second mask, 7:0 first mask; 1 enables the byte). Without a mask word the entry's mask is all ones.
- R11: For a matching extended word, the opcode fields act as follows. Bit 4 precharges `xw_bank`. Bits 3:2 = 10 give a calibrate strobe, and 11 give calibrate with `sam_stb`. Bit 1 requests standby. Any code with bit 0 set does nothing. The fields may be combined.
- R12: At most one strobe is active per cycle. The steps come in the order retire, read/load, retire, column precharge, extended precharge, calibrate, standby, starting the cycle after the slot is accepted. `busy` is high until the last step, and slots presented while `busy` is high are ignored.
- R13: A retire strobe occurs only when the buffer holds a valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_id | input | 5 | Programmed device ID |
| wake | input | 1 | Return from standby to attention |
| slot_vld | input | 1 | A command slot is present |
| cw_sel | input | 1 | Column word select flag |
| cw_dev | input | 5 | Column word device field |
| cw_op | input | 4 | Column opcode |
| cw_bank | input | 5 | Column word bank |
| cw_col | input | 6 | Column address |
| wr_data | input | 32 | Write data for a buffer load |
| xw_mask | input | 1 | Companion word carries byte masks |
| xw_dev | input | 5 | Companion word device field |
| xw_op | input | 5 | Extended opcode |
| xw_bank | input | 5 | Extended precharge bank |
| xw_mask_a | input | 8 | First byte mask |
| xw_mask_b | input | 8 | Second byte mask |
| busy | output | 1 | Step sequence in progress |
| attn | output | 1 | Device is in the attention state |
| ret_stb | output | 1 | Write-buffer retire strobe |
| ret_bank | output | 5 | Bank of retired entry |
| ret_col | output | 6 | Column of retired entry |
| ret_data | output | 32 | Data of retired entry |
| ret_mask | output | 16 | Byte mask of retired entry |
| ld_stb | output | 1 | Buffer load strobe |
| rd_stb | output | 1 | Column read strobe |
| rd_bank | output | 5 | Read bank |
| rd_col | output | 6 | Read column |
| pre_stb | output | 1 | Bank precharge strobe |
| pre_bank | output | 5 | Bank being precharged |
| cal_stb | output | 1 | Calibrate strobe |
| sam_stb | output | 1 | Sample qualifier with calibrate |
| stby_stb | output | 1 | Standby entry strobe |

## Verification
The bench aims at the buffer-dependent retires. A design that retired an empty buffer would show an extra leading retire on the first write. One that skipped the second retire of write-then-precharge would precharge a bank while its fresh data still sat in the buffer. Combined codes such as write plus standby, or extended precharge plus standby, are checked step by step, and a wrong priority order shows up as a permuted strobe train. Reserved extended codes with other bits set, mask words that carry an otherwise valid opcode, and a slot held high across a busy cycle are all expected to leave no trace. A design that let them through would add strobes or run a sequence twice.

// File: rtl/col_cmd_pkg.sv
package col_cmd_pkg;
  localparam int NPH = 8;

  // Step positions; lower index issues first.
  localparam int PH_RET1  = 0;
  localparam int PH_READ  = 1;
  localparam int PH_LOAD  = 2;
  localparam int PH_RET2  = 3;
  localparam int PH_PREC  = 4;
  localparam int PH_XPREC = 5;
  localparam int PH_CAL   = 6;
  localparam int PH_STBY  = 7;

  typedef logic [NPH-1:0] phase_vec_t;
endpackage

// File: rtl/col_cmd_decode.sv
module col_cmd_decode
  import col_cmd_pkg::*;
#(
  parameter int DEV_W = 5,
  parameter int OP_W  = 4,
  parameter int XOP_W = 5
) (
  input  logic [DEV_W-1:0] dev_id,
  input  logic             buf_valid,
  input  logic             cw_sel,
  input  logic [DEV_W-1:0] cw_dev,
  input  logic [OP_W-1:0]  cw_op,
  input  logic             xw_mask,
  input  logic [DEV_W-1:0] xw_dev,
  input  logic [XOP_W-1:0] xw_op,
  output phase_vec_t       plan,
  output logic             x_sample
);
  logic       c_hit, x_hit;
  logic [2:0] low;
  logic       is_wr, is_rd, c_pre, c_stby;
  logic       x_pre, x_cal, x_stby;

  always_comb begin
    c_hit  = cw_sel && (cw_dev == dev_id);
    x_hit  = !xw_mask && (xw_dev == dev_id) && !xw_op[0];
    low    = cw_op[2:0];
    is_wr  = c_hit && (low == 3'b001 || low == 3'b101);
    is_rd  = c_hit && (low == 3'b011 || low == 3'b111);
    c_pre  = c_hit && (low == 3'b100 || low == 3'b101 || low == 3'b111);
    c_stby = c_hit && cw_op[OP_W-1];
    x_pre  = x_hit && xw_op[4];
    x_cal  = x_hit && xw_op[3];
    x_stby = x_hit && xw_op[1];
    x_sample = x_cal && xw_op[2];

    plan           = '0;
    plan[PH_RET1]  = buf_valid && (is_wr || c_pre || x_pre);
    plan[PH_READ]  = is_rd;
    plan[PH_LOAD]  = is_wr;
    plan[PH_RET2]  = is_wr && (c_pre || x_pre);
    plan[PH_PREC]  = c_pre;
    plan[PH_XPREC] = x_pre;
    plan[PH_CAL]   = x_cal;
    plan[PH_STBY]  = c_stby || x_stby;
  end
endmodule

// File: rtl/col_cmd_seq.sv
module col_cmd_seq
  import col_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  phase_vec_t plan_in,
  input  logic       wake,
  output phase_vec_t cur,
  output logic       busy,
  output logic       attn
);
  phase_vec_t pend_q, pend_d;
  logic       attn_q, attn_d;

  // Lowest pending step is the one issued this cycle.
  always_comb begin
    cur = '0;
    for (int i = NPH - 1; i >= 0; i--) begin
      if (pend_q[i]) cur = phase_vec_t'(1) << i;
    end
  end

  always_comb begin
    pend_d = pend_q & ~cur;
    if (accept) pend_d = plan_in;
    attn_d = attn_q;
    if (cur[PH_STBY])        attn_d = 1'b0;
    else if (wake && !attn_q) attn_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      attn_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      attn_q <= attn_d;
    end
  end

  assign busy = |pend_q;
  assign attn = attn_q;
endmodule

// File: rtl/col_cmd_wbuf.sv
module col_cmd_wbuf #(
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int DATA_W = 32,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              retire_en,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  logic [DATA_W-1:0] in_data,
  input  logic [MASK_W-1:0] in_mask,
  output logic              valid,
  output logic [BANK_W-1:0] bank,
  output logic [COL_W-1:0]  col,
  output logic [DATA_W-1:0] data,
  output logic [MASK_W-1:0] mask
);
  logic valid_d;

  always_comb begin
    valid_d = valid;
    if (retire_en) valid_d = 1'b0;
    if (load_en)   valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_d;
  end

  // Payload needs no reset: it is only observed while valid.
  always_ff @(posedge clk) begin
    if (load_en) begin
      bank <= in_bank;
      col  <= in_col;
      data <= in_data;
      mask <= in_mask;
    end
  end
endmodule

// File: rtl/col_cmd_top.sv
module col_cmd_top
  import col_cmd_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int OP_W   = 4,
  parameter int XOP_W  = 5,
  parameter int BANK_W = 5,
  parameter int COL_W  = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEV_W-1:0]    dev_id,
  input  logic                wake,
  input  logic                slot_vld,
  input  logic                cw_sel,
  input  logic [DEV_W-1:0]    cw_dev,
  input  logic [OP_W-1:0]     cw_op,
  input  logic [BANK_W-1:0]   cw_bank,
  input  logic [COL_W-1:0]    cw_col,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                xw_mask,
  input  logic [DEV_W-1:0]    xw_dev,
  input  logic [XOP_W-1:0]    xw_op,
  input  logic [BANK_W-1:0]   xw_bank,
  input  logic [BYTE_W-1:0]   xw_mask_a,
  input  logic [BYTE_W-1:0]   xw_mask_b,
  output logic                busy,
  output logic                attn,
  output logic                ret_stb,
  output logic [BANK_W-1:0]   ret_bank,
  output logic [COL_W-1:0]    ret_col,
  output logic [DATA_W-1:0]   ret_data,
  output logic [2*BYTE_W-1:0] ret_mask,
  output logic                ld_stb,
  output logic                rd_stb,
  output logic [BANK_W-1:0]   rd_bank,
  output logic [COL_W-1:0]    rd_col,
  output logic                pre_stb,
  output logic [BANK_W-1:0]   pre_bank,
  output logic                cal_stb,
  output logic                sam_stb,
  output logic                stby_stb
);
  localparam int MASK_W = 2 * BYTE_W;

  phase_vec_t        plan, cur;
  logic              x_sample, accept, buf_valid;
  logic [BANK_W-1:0] bank_q, xbank_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] data_q;
  logic [MASK_W-1:0] mask_q, mask_in;
  logic              sam_q;

  assign accept  = slot_vld && attn && !busy;
  assign mask_in = xw_mask ? {xw_mask_b, xw_mask_a} : {MASK_W{1'b1}};

  col_cmd_decode #(.DEV_W(DEV_W), .OP_W(OP_W), .XOP_W(XOP_W)) u_dec (
    .dev_id(dev_id), .buf_valid(buf_valid),
    .cw_sel(cw_sel), .cw_dev(cw_dev), .cw_op(cw_op),
    .xw_mask(xw_mask), .xw_dev(xw_dev), .xw_op(xw_op),
    .plan(plan), .x_sample(x_sample)
  );

  col_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .plan_in(plan),
    .wake(wake), .cur(cur), .busy(busy), .attn(attn)
  );

  // Slot operands held for the duration of the step train.
  always_ff @(posedge clk) begin
    if (accept) begin
      bank_q  <= cw_bank;
      col_q   <= cw_col;
      data_q  <= wr_data;
      mask_q  <= mask_in;
      xbank_q <= xw_bank;
      sam_q   <= x_sample;
    end
  end

  col_cmd_wbuf #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .MASK_W(MASK_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .load_en(cur[PH_LOAD]), .retire_en(ret_stb),
    .in_bank(bank_q), .in_col(col_q), .in_data(data_q), .in_mask(mask_q),
    .valid(buf_valid), .bank(ret_bank), .col(ret_col),
    .data(ret_data), .mask(ret_mask)
  );

  always_comb begin
    ret_stb  = cur[PH_RET1] || cur[PH_RET2];
    ld_stb   = cur[PH_LOAD];
    rd_stb   = cur[PH_READ];
    rd_bank  = bank_q;
    rd_col   = col_q;
    pre_stb  = cur[PH_PREC] || cur[PH_XPREC];
    pre_bank = cur[PH_XPREC] ? xbank_q : bank_q;
    cal_stb  = cur[PH_CAL];
    sam_stb  = cur[PH_CAL] && sam_q;
    stby_stb = cur[PH_STBY];
  end
endmodule

// File: rtl/col_cmd_chk.sv
module col_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic wake,
  input logic busy,
  input logic attn,
  input logic ret_stb,
  input logic ld_stb,
  input logic rd_stb,
  input logic pre_stb,
  input logic cal_stb,
  input logic sam_stb,
  input logic stby_stb
);
  logic any_stb;
  assign any_stb = ret_stb | ld_stb | rd_stb | pre_stb | cal_stb | stby_stb;

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ret_stb, ld_stb, rd_stb, pre_stb, cal_stb, stby_stb}));

  a_r12_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> busy);

  a_r9_stby_drops: assert property (@(posedge clk) disable iff (!rst_n)
    stby_stb |=> !attn);

  a_r3_wake_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!attn && wake) |=> attn);

  a_r3_idle_in_stby: assert property (@(posedge clk) disable iff (!rst_n)
    !attn |-> !busy);

  a_r11_sam_cal: assert property (@(posedge clk) disable iff (!rst_n)
    sam_stb |-> cal_stb);

  a_r9_stby_last: assert property (@(posedge clk) disable iff (!rst_n)
    stby_stb |=> !busy);
endmodule

bind col_cmd_top col_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wake(wake), .busy(busy), .attn(attn),
  .ret_stb(ret_stb), .ld_stb(ld_stb), .rd_stb(rd_stb), .pre_stb(pre_stb),
  .cal_stb(cal_stb), .sam_stb(sam_stb), .stby_stb(stby_stb)
);

// File: tb/col_cmd_top_tb.sv
module col_cmd_top_tb;
  logic        clk, rst_n, wake, slot_vld;
  logic [4:0]  dev_id, cw_dev, cw_bank, xw_dev, xw_op, xw_bank;
  logic        cw_sel, xw_mask;
  logic [3:0]  cw_op;
  logic [5:0]  cw_col;
  logic [31:0] wr_data;
  logic [7:0]  xw_mask_a, xw_mask_b;
  logic        busy, attn, ret_stb, ld_stb, rd_stb, pre_stb, cal_stb, sam_stb, stby_stb;
  logic [4:0]  ret_bank, rd_bank, pre_bank;
  logic [5:0]  ret_col, rd_col;
  logic [31:0] ret_data;
  logic [15:0] ret_mask;

  col_cmd_top u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // Step codes, first step in the top nibble: 1 retire, 2 load, 3 read,
  // 4 precharge, 5 calibrate, 6 calibrate+sample, 7 standby, F several.
  typedef struct packed {
    logic       sel; logic [4:0] cdev; logic [3:0] cop;
    logic       xm;  logic [4:0] xdev; logic [4:0] xop;
    logic [31:0] seq;
  } vec_t;

  localparam vec_t VECS [0:21] = '{
    '{1'b1, 5'd9, 4'h3, 1'b0, 5'd0, 5'h00, 32'h3000_0000}, // R4 read
    '{1'b1, 5'd9, 4'h1, 1'b0, 5'd0, 5'h00, 32'h2000_0000}, // R1 R13 empty buffer
    '{1'b1, 5'd9, 4'h1, 1'b0, 5'd0, 5'h00, 32'h1200_0000}, // R5
    '{1'b1, 5'd9, 4'h4, 1'b0, 5'd0, 5'h00, 32'h1400_0000}, // R6
    '{1'b1, 5'd9, 4'h4, 1'b0, 5'd0, 5'h00, 32'h4000_0000}, // R6 R13
    '{1'b1, 5'd9, 4'h5, 1'b0, 5'd0, 5'h00, 32'h2140_0000}, // R7
    '{1'b1, 5'd9, 4'h7, 1'b0, 5'd0, 5'h00, 32'h3400_0000}, // R8
    '{1'b1, 5'd9, 4'h2, 1'b0, 5'd0, 5'h00, 32'h0000_0000}, // R4 reserved
    '{1'b1, 5'd9, 4'h6, 1'b0, 5'd0, 5'h00, 32'h0000_0000}, // R4 reserved
    '{1'b1, 5'd3, 4'h1, 1'b0, 5'd0, 5'h00, 32'h0000_0000}, // R2 device
    '{1'b0, 5'd9, 4'h1, 1'b0, 5'd0, 5'h00, 32'h0000_0000}, // R2 select
    '{1'b1, 5'd9, 4'h1, 1'b0, 5'd0, 5'h00, 32'h2000_0000}, // R5
    '{1'b1, 5'd9, 4'h7, 1'b0, 5'd0, 5'h00, 32'h1340_0000}, // R8 with retire
    '{1'b0, 5'd9, 4'h0, 1'b0, 5'd9, 5'h10, 32'h4000_0000}, // R11 precharge
    '{1'b0, 5'd9, 4'h0, 1'b0, 5'd9, 5'h08, 32'h5000_0000}, // R11 calibrate
    '{1'b0, 5'd9, 4'h0, 1'b0, 5'd9, 5'h0C, 32'h6000_0000}, // R11 cal+sample
    '{1'b0, 5'd9, 4'h0, 1'b0, 5'd9, 5'h11, 32'h0000_0000}, // R11 reserved
    '{1'b1, 5'd9, 4'h1, 1'b0, 5'd9, 5'h10, 32'h2140_0000}, // R12 write+xprecharge
    '{1'b1, 5'd9, 4'h3, 1'b0, 5'd9, 5'h08, 32'h3500_0000}, // R12 read+cal
    '{1'b0, 5'd9, 4'h0, 1'b0, 5'd4, 5'h10, 32'h0000_0000}, // R2 ext device
    '{1'b1, 5'd9, 4'h1, 1'b1, 5'd9, 5'h10, 32'h2000_0000}, // R2 mask word no op
    '{1'b1, 5'd9, 4'h9, 1'b0, 5'd0, 5'h00, 32'h1270_0000}  // R9 write+standby
  };

  logic [4:0]  cap_ret_bank, cap_pre_bank, cap_rd_bank;
  logic [5:0]  cap_ret_col, cap_rd_col;
  logic [31:0] cap_ret_data;
  logic [15:0] cap_ret_mask;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_now();
    int n;
    logic [3:0] c;
    n = int'(ret_stb) + int'(ld_stb) + int'(rd_stb) + int'(pre_stb) + int'(cal_stb) + int'(stby_stb);
    c = 4'h0;
    if (ret_stb)  c = 4'h1;
    if (ld_stb)   c = 4'h2;
    if (rd_stb)   c = 4'h3;
    if (pre_stb)  c = 4'h4;
    if (cal_stb)  c = sam_stb ? 4'h6 : 4'h5;
    if (stby_stb) c = 4'h7;
    if (n > 1)    c = 4'hF;
    return c;
  endfunction

  // Presents one slot for 'hold' cycles, then records eight cycles of steps.
  task automatic run_slot(input logic sel, input logic [4:0] cdev, input logic [3:0] cop,
                          input logic xm, input logic [4:0] xdev, input logic [4:0] xop,
                          input int hold, output logic [31:0] obs);
    obs = '0;
    @(negedge clk);
    slot_vld = 1'b1; cw_sel = sel; cw_dev = cdev; cw_op = cop;
    xw_mask = xm; xw_dev = xdev; xw_op = xop;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i + 1 >= hold) slot_vld = 1'b0;
      obs = obs | (32'(code_now()) << (28 - 4 * i));
      if (ret_stb) begin
        cap_ret_bank = ret_bank; cap_ret_col = ret_col;
        cap_ret_data = ret_data; cap_ret_mask = ret_mask;
      end
      if (pre_stb) cap_pre_bank = pre_bank;
      if (rd_stb) begin cap_rd_bank = rd_bank; cap_rd_col = rd_col; end
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [31:0] obs;
    rst_n = 1'b0; wake = 1'b0; slot_vld = 1'b0; dev_id = 5'd9;
    cw_sel = 0; cw_dev = 0; cw_op = 0; cw_bank = 5'd1; cw_col = 6'd2; wr_data = 32'h0;
    xw_mask = 0; xw_dev = 0; xw_op = 0; xw_bank = 5'd6; xw_mask_a = 8'h00; xw_mask_b = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", 64'(busy), 0);
    chk(attn == 1'b1, "R1 attn", 64'(attn), 1);
    chk(code_now() == 4'h0, "R1 strobes", 64'(code_now()), 0);

    foreach (VECS[i]) begin
      wr_data = 32'(i);
      run_slot(VECS[i].sel, VECS[i].cdev, VECS[i].cop, VECS[i].xm, VECS[i].xdev, VECS[i].xop, 1, obs);
      chk(obs == VECS[i].seq, $sformatf("R12 vector %0d", i), 64'(obs), 64'(VECS[i].seq));
    end
    chk(attn == 1'b0, "R9 attn after standby", 64'(attn), 0);

    // R3 ignored in standby, then wake
    run_slot(1, 5'd9, 4'h3, 0, 5'd0, 5'h00, 1, obs);
    chk(obs == 0 && busy == 0, "R3 ignored in standby", 64'(obs), 0);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    chk(attn == 1'b1, "R3 wake", 64'(attn), 1);

    // R10 masks travel with the write; R5 retire shows previous entry
    cw_bank = 5'd3; cw_col = 6'd5; wr_data = 32'hA1A1_0001;
    xw_mask_a = 8'h5A; xw_mask_b = 8'hC3;
    run_slot(1, 5'd9, 4'h1, 1, 5'd0, 5'h00, 1, obs);
    chk(obs == 32'h1200_0000, "R5 write over valid entry", 64'(obs), 64'h1200_0000);
    cw_bank = 5'd4; cw_col = 6'd6; wr_data = 32'hB2B2_0002;
    run_slot(1, 5'd9, 4'h1, 0, 5'd0, 5'h00, 1, obs);
    chk(cap_ret_data == 32'hA1A1_0001, "R5 retired data", 64'(cap_ret_data), 64'hA1A1_0001);
    chk(cap_ret_mask == 16'hC35A, "R10 retired mask", 64'(cap_ret_mask), 64'hC35A);
    chk({cap_ret_bank, cap_ret_col} == {5'd3, 6'd5}, "R5 retired address",
        64'({cap_ret_bank, cap_ret_col}), 64'({5'd3, 6'd5}));
    cw_bank = 5'd2;
    run_slot(1, 5'd9, 4'h4, 0, 5'd0, 5'h00, 1, obs);
    chk(cap_ret_data == 32'hB2B2_0002 && cap_ret_mask == 16'hFFFF, "R10 default mask",
        64'({cap_ret_data, cap_ret_mask}), 64'({32'hB2B2_0002, 16'hFFFF}));
    chk(cap_pre_bank == 5'd2, "R6 precharge bank", 64'(cap_pre_bank), 2);

    // R4 read address
    cw_bank = 5'd7; cw_col = 6'd33;
    run_slot(1, 5'd9, 4'h3, 0, 5'd0, 5'h00, 1, obs);
    chk({cap_rd_bank, cap_rd_col} == {5'd7, 6'd33}, "R4 read address",
        64'({cap_rd_bank, cap_rd_col}), 64'({5'd7, 6'd33}));

    // R11 extended precharge plus standby
    xw_bank = 5'd11;
    run_slot(0, 5'd9, 4'h0, 0, 5'd9, 5'h12, 1, obs);
    chk(obs == 32'h4700_0000, "R11 precharge+standby", 64'(obs), 64'h4700_0000);
    chk(cap_pre_bank == 5'd11, "R11 extended bank", 64'(cap_pre_bank), 11);
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;

    // R12 slot held across busy is taken once
    run_slot(1, 5'd9, 4'h5, 0, 5'd0, 5'h00, 2, obs);
    chk(obs == 32'h2140_0000, "R12 held slot taken once", 64'(obs), 64'h2140_0000);
    run_slot(1, 5'd9, 4'h1, 0, 5'd0, 5'h00, 1, obs);
    chk(obs == 32'h2000_0000, "R13 buffer drained", 64'(obs), 64'h2000_0000);

    done = 1;
    summary();
  end
endmodule